// File: doc/BRIEF.md
# Key-Locked DRAM Controller Register Bank

This block holds the software-visible control and status words of a DRAM controller. A host reaches it through a simple synchronous register port: a byte address into a 4 KB window, a write strobe, a read strobe and 32-bit data. Every access is one whole 32-bit word. The two low address bits are ignored. The word index is `bus_addr[11:2]`.

Word 0 is a protection register. Every other word accepts writes only after the exact unlock key has been written to word 0. Word 1 is a configuration word. Its hardware-owned fields are rebuilt on every write from fixed values. One of those fields is a 2-bit DRAM size code, derived at elaboration time from the `RAM_MB` parameter.

A `VARIANT` parameter chooses between two layouts:
- `VARIANT=0` is the older layout.
- `VARIANT=1` is the newer layout, which is the default.

In the newer layout, the PHY status word and the ECC self-test word are forced on every write. As a result, the controller always reports itself idle and the self-test always reads as finished without failure.

Top module: `memctl_keyed_regs`

## Requirements
- R1: A write of exactly 0xFC600309 to offset 0x00 stores 1 there. A write of any other value to offset 0x00 stores 0. Bits 31:1 of offset 0x00 always read 0. Writes to offset 0x00 are accepted whether or not the bank is locked.
- R2: While offset 0x00 holds 0, writes to every other offset are discarded. Reads still return the stored contents.
- R3: A write to the configuration word at offset 0x04 stores the written data with the read-only mask cleared, OR'd with the fixed value.
  - Newer layout: mask 0xF00FC04F, fixed value 0x1008000C plus the size code. Bits 31:28 read 1, bit 19 reads 1, bits 18:14 read 0, bit 6 reads 0, bits 3:2 read 3.
  - Older layout: mask 0xFFFFF84F, fixed value 0x40 plus the size code. Bits 31:11 read 0, bit 6 reads 1, bits 3:2 read 0.
- R4: The size code sits in bits 1:0 of the configuration word and is read-only.
  - Older layout: 64, 128, 256 and 512 MB map to codes 0 to 3.
  - Newer layout: 128, 256, 512 and 1024 MB map to codes 0 to 3.
  - Any other `RAM_MB` value gives code 2 in both layouts.
- R5: After reset, every word reads 0 except the configuration word, which reads its fixed value.
- R6: In the newer layout, a write to offset 0x60 always stores bit 0 as 0. Its other bits are stored as written.
- R7: In the newer layout, a write to offset 0x70 always stores bit 12 as 1 and bit 13 as 0. In the older layout, offset 0x70 stores data unchanged.
- R8: Offsets at or beyond `NUM_REGS*4` (default 0x80) ignore writes, and reads there return 0.
- R9: Read data is registered.
  - `bus_rdata` changes only on the clock edge that samples `bus_rd`, and then holds.
  - A read and a write to the same word in one cycle return the value held before the write.
- R10: While unlocked, an ordinary word such as offset 0x08 stores and returns the full 32-bit value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte address within the 4 KB window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |

## Verification
The embedded assertions check the following invariants on every cycle:
- The protection word holds only one bit.
- The configuration word always carries its fixed read-only pattern.
- In the newer layout, the PHY-busy bit never reads 1 and the self-test fail bit never reads 1.
- A locked write to the configuration word leaves it unchanged.
- Out-of-range reads return zero.
- Registered reads reflect the word as it stood in the previous cycle.

Only the bench's scenarios can show the following:
- The exact key comparison and re-locking on a wrong key.
- The full stored value after masking.
- The size-code fallback for an illegal RAM size.
- The read-before-write ordering when a read and a write hit the same word.
- That ordinary words keep all 32 written bits.

// File: rtl/memctl_keyed_regs.sv
module memctl_keyed_regs #(
  parameter int VARIANT  = 1,
  parameter int RAM_MB   = 512,
  parameter int NUM_REGS = 32,
  parameter int ADDR_W   = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [11:0] bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata
);

  localparam int IDX_W    = ADDR_W - 2;
  localparam int SEL_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam int PROT_IDX = 0;
  localparam int CONF_IDX = 1;
  localparam int STAT_IDX = 24;
  localparam int ECC_IDX  = 28;
  localparam logic [31:0] UNLOCK_KEY = 32'hFC60_0309;

  function automatic logic [1:0] size_code(input int v, input int mb);
    if (v == 0) begin
      case (mb)
        64:      return 2'd0;
        128:     return 2'd1;
        256:     return 2'd2;
        512:     return 2'd3;
        default: return 2'd2;
      endcase
    end else begin
      case (mb)
        128:     return 2'd0;
        256:     return 2'd1;
        512:     return 2'd2;
        1024:    return 2'd3;
        default: return 2'd2;
      endcase
    end
  endfunction

  localparam logic [1:0]  SIZE_CODE  = size_code(VARIANT, RAM_MB);
  localparam logic [31:0] CONF_MASK  = (VARIANT != 0) ? 32'hF00F_C04F : 32'hFFFF_F84F;
  localparam logic [31:0] CONF_FIXED = ((VARIANT != 0) ? 32'h1008_000C : 32'h0000_0040)
                                       | {30'd0, SIZE_CODE};

  logic [31:0] regs [NUM_REGS];
  logic [31:0] wr_val;

  wire [IDX_W-1:0] idx      = bus_addr[ADDR_W-1:2];
  wire             in_range = (int'(idx) < NUM_REGS);
  wire [SEL_W-1:0] slot     = idx[SEL_W-1:0];
  wire             unlocked = regs[PROT_IDX][0];

  always_comb begin
    wr_val = bus_wdata;
    if (int'(idx) == CONF_IDX)
      wr_val = (bus_wdata & ~CONF_MASK) | CONF_FIXED;
    else if (VARIANT != 0 && int'(idx) == STAT_IDX)
      wr_val = bus_wdata & ~32'h1;
    else if (VARIANT != 0 && int'(idx) == ECC_IDX)
      wr_val = (bus_wdata | 32'h1000) & ~32'h2000;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
      regs[CONF_IDX] <= CONF_FIXED;
      bus_rdata      <= '0;
    end else begin
      if (bus_rd) bus_rdata <= in_range ? regs[slot] : 32'd0;
      if (bus_wr && in_range) begin
        if (int'(idx) == PROT_IDX) regs[PROT_IDX] <= {31'd0, bus_wdata == UNLOCK_KEY};
        else if (unlocked)         regs[slot] <= wr_val;
      end
    end
  end

  p_prot_onebit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    regs[PROT_IDX][31:1] == 31'd0);

  p_locked_conf_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !unlocked && int'(idx) == CONF_IDX) |=> $stable(regs[CONF_IDX]));

  p_conf_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (regs[CONF_IDX] & CONF_MASK) == CONF_FIXED);

  p_oor_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !in_range) |=> bus_rdata == 32'd0);

  p_read_prev_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && in_range) |=> bus_rdata == $past(regs[slot]));

  generate
    if (VARIANT != 0 && NUM_REGS > ECC_IDX) begin : g_newer
      p_phy_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        regs[STAT_IDX][0] == 1'b0);
      p_ecc_nofail_r7: assert property (@(posedge clk) disable iff (!rst_n)
        regs[ECC_IDX][13] == 1'b0);
      p_ecc_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && unlocked && int'(idx) == ECC_IDX) |=> regs[ECC_IDX][12]);
    end
  endgenerate

endmodule

// File: tb/memctl_keyed_regs_bench.sv
module memctl_keyed_regs_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rd_new, rd_old;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  memctl_keyed_regs u_memctl_keyed_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(rd_new));

  memctl_keyed_regs #(.VARIANT(0), .RAM_MB(300)) u_memctl_keyed_regs_old (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(rd_old));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [11:0] a);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic t_reset_r5;
    rd(12'h004); check("R5 conf new", rd_new, 32'h1008_000E); check("R4 R5 conf old fallback", rd_old, 32'h0000_0042);
    rd(12'h000); check("R5 prot", rd_new, 0);
    rd(12'h070); check("R5 ecc", rd_new, 0);
  endtask

  task automatic t_locked_r2;
    wr(12'h008, 32'hDEAD_BEEF);
    rd(12'h008); check("R2 locked write", rd_new, 0);
    wr(12'h004, 32'hFFFF_FFFF);
    rd(12'h004); check("R2 locked conf", rd_new, 32'h1008_000E);
  endtask

  task automatic t_unlock_r1;
    wr(12'h000, 32'hFC60_0309);
    rd(12'h000); check("R1 unlock", rd_new, 1);
    wr(12'h008, 32'hA5A5_5A5A);
    rd(12'h008); check("R10 plain store", rd_new, 32'hA5A5_5A5A);
    wr(12'h000, 32'hFC60_0308);
    rd(12'h000); check("R1 wrong key relocks", rd_new, 0);
    wr(12'h008, 32'h1234_5678);
    rd(12'h008); check("R2 relocked keeps", rd_new, 32'hA5A5_5A5A);
    wr(12'h000, 32'hFC60_0309);
  endtask

  task automatic t_conf_r3;
    wr(12'h004, 32'hFFFF_FFFF);
    rd(12'h004); check("R3 conf ones new", rd_new, 32'h1FF8_3FBE); check("R3 conf ones old", rd_old, 32'h0000_07F2);
    wr(12'h004, 32'h0);
    rd(12'h004); check("R3 R4 conf zero new", rd_new, 32'h1008_000E); check("R3 conf zero old", rd_old, 32'h0000_0042);
  endtask

  task automatic t_status_r6;
    wr(12'h060, 32'hFFFF_FFFF);
    rd(12'h060); check("R6 phy idle", rd_new, 32'hFFFF_FFFE); check("R6 old plain", rd_old, 32'hFFFF_FFFF);
  endtask

  task automatic t_ecc_r7;
    wr(12'h070, 32'hFFFF_FFFF);
    rd(12'h070); check("R7 ecc ones", rd_new, 32'hFFFF_DFFF);
    wr(12'h070, 32'h0);
    rd(12'h070); check("R7 ecc zero", rd_new, 32'h0000_1000); check("R7 old plain", rd_old, 0);
  endtask

  task automatic t_oor_r8;
    wr(12'h100, 32'hFFFF_FFFF);
    rd(12'h100); check("R8 oor read", rd_new, 0);
    rd(12'h000); check("R8 oor write alias", rd_new, 1);
  endtask

  task automatic t_timing_r9;
    wr(12'h00C, 32'h1111_1111);
    @(negedge clk); bus_addr = 12'h00C; bus_wdata = 32'h2222_2222; bus_wr = 1; bus_rd = 1;
    @(negedge clk); bus_wr = 0; bus_rd = 0;
    check("R9 read before write", rd_new, 32'h1111_1111);
    @(negedge clk); check("R9 holds", rd_new, 32'h1111_1111);
    rd(12'h00C); check("R9 new value", rd_new, 32'h2222_2222);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset_r5(); t_locked_r2(); t_unlock_r1(); t_conf_r3();
    t_status_r6(); t_ecc_r7(); t_oor_r8(); t_timing_r9();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule